// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block holds eight recently used page mappings and translates 16-bit virtual addresses into 16-bit physical addresses. Pages are 256 bytes. The low 8 bits of an address pass through unchanged. The upper 8 bits, the virtual page number, are compared against every stored tag at once. A lookup is combinational: the physical address, the hit flag, the fault flags and the dirty state of the matched entry are valid in the same cycle as the request.

When a lookup misses, an external table walker installs the missing mapping through the refill port. Each entry keeps a 3-bit recency rank. Taken together, the ranks always form a permutation of 0 to 7, with 0 as the most recent. The refill slot comes from these ranks and from the valid bits. The slot a refill would take is always shown on `victim_slot`.

A pulse on `base_wr` marks a write to the translation base register. It clears every mapping in the following edge, exactly as a reset does.

Top module: `vpage_tlb`

## Requirements
- R1: On a hit, `lk_paddr` equals the entry's physical page number concatenated with `lk_vaddr[7:0]`. When there is no hit, `lk_paddr` is 0.
- R2: `lk_hit` is 1 when `lk_valid` is 1 and a valid entry's tag equals `lk_vaddr[15:8]`. At most one entry ever matches.
- R3: Permission bit 0 allows reads and bit 1 allows writes (`lk_write`=1 means write). A hit whose requested operation is not allowed raises `lk_prot_fault`. Such an access changes neither ranks nor dirty bits.
- R4: A write hit without a fault sets the entry's dirty bit at the next edge. `lk_dirty` shows the matched entry's dirty bit and is 0 on a miss.
- R5: A touched entry takes rank 0. A touch is a lookup hit without a fault, or a refill. Every entry whose rank was below the touched entry's old rank increments by one. All other ranks hold, so the ranks stay a permutation of 0..7.
- R6: `lk_page_fault` is 1 exactly when `lk_valid` is 1 and there is no hit.
- R7: `victim_slot` is the lowest-index invalid entry if one exists, otherwise the entry whose rank is 7. A refill writes that slot, except when the refilled page number is already present, in which case that entry is overwritten.
- R8: After reset or a `base_wr` pulse, every entry is invalid and clean, and entry i has rank i. `base_wr` takes priority over a refill in the same cycle.
- R9: When a refill and a lookup occur in the same cycle, only the refill updates state. The lookup outputs remain valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 16 | Virtual address to translate |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| lk_hit | output | 1 | Translation found |
| lk_paddr | output | 16 | Translated physical address |
| lk_page_fault | output | 1 | No valid mapping for the page |
| lk_prot_fault | output | 1 | Permissions forbid the access |
| lk_dirty | output | 1 | Dirty bit of the matched entry |
| fill_valid | input | 1 | Install a mapping |
| fill_vpn | input | 8 | Virtual page number to install |
| fill_ppn | input | 8 | Physical page number to install |
| fill_perm | input | 2 | Permissions (bit 0 read, bit 1 write) |
| fill_dirty | input | 1 | Initial dirty state of the mapping |
| base_wr | input | 1 | Base register written: flush all entries |
| victim_slot | output | 3 | Slot the next refill would use |

## Verification
The assertions check four things on every cycle:
- the eight ranks form a permutation;
- at most one tag matches;
- a touched entry reads rank 0 afterwards, a faulting access leaves ranks and dirty bits unchanged, and a write hit leaves its entry dirty;
- a flush leaves nothing valid.

Only the bench's scenarios can show the rest. That covers the exact recency order seen through `victim_slot` over long access sequences, and the reuse of an existing slot on a duplicate refill. It also covers the refill/lookup and flush/refill priorities and the translated addresses themselves. A reference model in the bench predicts each of these.

// File: rtl/vpage_tlb_pkg.sv
package vpage_tlb_pkg;
  // Positions of the permission bits in an entry.
  localparam int PERM_RD = 0;
  localparam int PERM_WR = 1;

  // True when the permissions allow the requested access.
  function automatic logic perm_allows(input logic [1:0] perm, input logic is_write);
    return is_write ? perm[PERM_WR] : perm[PERM_RD];
  endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N     = 8,
  parameter int VPN_W = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0][VPN_W-1:0] tags_i,
  input  logic [N-1:0]            valid_i,
  input  logic [VPN_W-1:0]        key_i,
  output logic [N-1:0]            hit_vec_o,
  output logic                    hit_o,
  output logic [IDX_W-1:0]        hit_idx_o
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_cmp
      assign hit_vec_o[g] = valid_i[g] && (tags_i[g] == key_i);
    end
  endgenerate

  assign hit_o = |hit_vec_o;

  always_comb begin
    hit_idx_o = '0;
    for (int i = 0; i < N; i++)
      if (hit_vec_o[i]) hit_idx_o = hit_idx_o | IDX_W'(i);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]            valid_i,
  input  logic [N-1:0][IDX_W-1:0] ranks_i,
  output logic [IDX_W-1:0]        victim_o
);
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(N - 1);

  logic             free_found;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] old_idx;

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    old_idx = '0;
    for (int i = 0; i < N; i++)
      if (ranks_i[i] == OLDEST) old_idx = IDX_W'(i);
  end

  assign victim_o = free_found ? free_idx : old_idx;
endmodule

// File: rtl/tlb_age.sv
module tlb_age #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear_i,
  input  logic                    touch_i,
  input  logic [IDX_W-1:0]        touch_idx_i,
  output logic [N-1:0][IDX_W-1:0] ranks_o
);
  logic [N-1:0][IDX_W-1:0] rank_q;
  logic [IDX_W-1:0]        pivot;

  assign pivot = rank_q[touch_idx_i];

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      for (int i = 0; i < N; i++) rank_q[i] <= IDX_W'(i);
    end else if (touch_i) begin
      for (int i = 0; i < N; i++) begin
        if (IDX_W'(i) == touch_idx_i) rank_q[i] <= '0;
        else if (rank_q[i] < pivot)   rank_q[i] <= rank_q[i] + 1'b1;
      end
    end
  end

  assign ranks_o = rank_q;
endmodule

// File: rtl/vpage_tlb.sv
module vpage_tlb
  import vpage_tlb_pkg::*;
#(
  parameter int VA_W    = 16,
  parameter int PA_W    = 16,
  parameter int OFF_W   = 8,
  parameter int ENTRIES = 8,
  parameter int PERM_W  = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        lk_valid,
  input  logic [VA_W-1:0]             lk_vaddr,
  input  logic                        lk_write,
  output logic                        lk_hit,
  output logic [PA_W-1:0]             lk_paddr,
  output logic                        lk_page_fault,
  output logic                        lk_prot_fault,
  output logic                        lk_dirty,
  input  logic                        fill_valid,
  input  logic [VA_W-OFF_W-1:0]       fill_vpn,
  input  logic [PA_W-OFF_W-1:0]       fill_ppn,
  input  logic [PERM_W-1:0]           fill_perm,
  input  logic                        fill_dirty,
  input  logic                        base_wr,
  output logic [$clog2(ENTRIES)-1:0]  victim_slot
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int IDX_W = $clog2(ENTRIES);

  // Entry storage: tags, page numbers and permissions are plain memories.
  logic [ENTRIES-1:0][VPN_W-1:0]  tag_q;
  logic [ENTRIES-1:0][PPN_W-1:0]  ppn_q;
  logic [ENTRIES-1:0][PERM_W-1:0] perm_q;
  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0]             dirty_q;
  logic [ENTRIES-1:0][IDX_W-1:0]  ranks;

  logic [ENTRIES-1:0] hit_vec;
  logic               hit_any;
  logic [IDX_W-1:0]   hit_idx;
  logic [ENTRIES-1:0] fhit_vec;
  logic               fhit_any;
  logic [IDX_W-1:0]   fhit_idx;
  logic [IDX_W-1:0]   victim_idx;

  logic               fill_go;
  logic [IDX_W-1:0]   fill_slot;
  logic               access_ok;
  logic               upd_lookup;
  logic               touch_en;
  logic [IDX_W-1:0]   touch_idx;

  tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_lk_match (
    .tags_i(tag_q), .valid_i(valid_q), .key_i(lk_vaddr[VA_W-1:OFF_W]),
    .hit_vec_o(hit_vec), .hit_o(hit_any), .hit_idx_o(hit_idx)
  );

  tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_fill_match (
    .tags_i(tag_q), .valid_i(valid_q), .key_i(fill_vpn),
    .hit_vec_o(fhit_vec), .hit_o(fhit_any), .hit_idx_o(fhit_idx)
  );

  tlb_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .valid_i(valid_q), .ranks_i(ranks), .victim_o(victim_idx)
  );

  // Lookup side
  assign lk_hit        = lk_valid && hit_any;
  assign access_ok     = perm_allows(perm_q[hit_idx], lk_write);
  assign lk_prot_fault = lk_hit && !access_ok;
  assign lk_page_fault = lk_valid && !hit_any;
  assign lk_paddr      = lk_hit ? {ppn_q[hit_idx], lk_vaddr[OFF_W-1:0]} : '0;
  assign lk_dirty      = lk_hit && dirty_q[hit_idx];
  assign victim_slot   = victim_idx;

  // Update arbitration: flush > refill > lookup
  assign fill_go    = fill_valid && !base_wr;
  assign fill_slot  = fhit_any ? fhit_idx : victim_idx;
  assign upd_lookup = lk_hit && access_ok && !fill_valid && !base_wr;
  assign touch_en   = fill_go || upd_lookup;
  assign touch_idx  = fill_go ? fill_slot : hit_idx;

  tlb_age #(.N(ENTRIES), .IDX_W(IDX_W)) u_age (
    .clk(clk), .rst(rst), .clear_i(base_wr),
    .touch_i(touch_en), .touch_idx_i(touch_idx), .ranks_o(ranks)
  );

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_entry
      logic sel_fill;
      logic sel_dirty;
      assign sel_fill  = fill_go && (fill_slot == IDX_W'(g));
      assign sel_dirty = upd_lookup && lk_write && (hit_idx == IDX_W'(g));

      // Payload: written without reset
      always_ff @(posedge clk) begin
        if (sel_fill) begin
          tag_q[g]  <= fill_vpn;
          ppn_q[g]  <= fill_ppn;
          perm_q[g] <= fill_perm;
        end
      end

      // Flags: cleared by reset and flush
      always_ff @(posedge clk) begin
        if (rst || base_wr) begin
          valid_q[g] <= 1'b0;
          dirty_q[g] <= 1'b0;
        end else if (sel_fill) begin
          valid_q[g] <= 1'b1;
          dirty_q[g] <= fill_dirty;
        end else if (sel_dirty) begin
          dirty_q[g] <= 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/vpage_tlb_chk.sv
module vpage_tlb_chk #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    lk_valid,
  input logic                    lk_write,
  input logic                    lk_prot_fault,
  input logic                    lk_hit,
  input logic                    lk_page_fault,
  input logic                    fill_valid,
  input logic                    base_wr,
  input logic                    upd_lookup,
  input logic                    touch_en,
  input logic [IDX_W-1:0]        touch_idx,
  input logic [IDX_W-1:0]        hit_idx,
  input logic [N-1:0]            hit_vec,
  input logic [N-1:0]            valid_q,
  input logic [N-1:0]            dirty_q,
  input logic [N-1:0][IDX_W-1:0] ranks
);
  logic [IDX_W-1:0] hit_idx_d;
  logic [IDX_W-1:0] touch_idx_d;
  always_ff @(posedge clk) begin
    hit_idx_d   <= hit_idx;
    touch_idx_d <= touch_idx;
  end

  // R2: at most one tag matches
  p_single_match_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  // R6: miss and page fault go together
  p_pf_on_miss_r6: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !lk_hit) |-> lk_page_fault);
  p_pf_no_hit_r6: assert property (@(posedge clk) disable iff (rst)
    lk_page_fault |-> !lk_hit);

  // R4: a write hit that is allowed leaves the entry dirty
  p_dirty_set_r4: assert property (@(posedge clk) disable iff (rst)
    (upd_lookup && lk_write && !base_wr) |=> dirty_q[hit_idx_d]);

  // R3: a faulting access changes neither ranks nor dirty bits
  p_fault_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (lk_prot_fault && !fill_valid && !base_wr) |=> ($stable(dirty_q) && $stable(ranks)));

  // R5: a touched entry becomes most recent
  p_mru_r5: assert property (@(posedge clk) disable iff (rst)
    (touch_en && !base_wr) |=> (ranks[touch_idx_d] == '0));

  // R8: a flush leaves nothing valid or dirty
  p_flush_r8: assert property (@(posedge clk) disable iff (rst)
    base_wr |=> (valid_q == '0 && dirty_q == '0));

  // R5: ranks remain a permutation
  genvar v;
  generate
    for (v = 0; v < N; v++) begin : g_perm
      logic [N-1:0] holds;
      for (genvar e = 0; e < N; e++) begin : g_e
        assign holds[e] = (ranks[e] == IDX_W'(v));
      end
      p_rank_perm_r5: assert property (@(posedge clk) disable iff (rst)
        $countones(holds) == 1);
    end
  endgenerate
endmodule

bind vpage_tlb vpage_tlb_chk #(.N(ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_write(lk_write),
  .lk_prot_fault(lk_prot_fault), .lk_hit(lk_hit), .lk_page_fault(lk_page_fault),
  .fill_valid(fill_valid), .base_wr(base_wr), .upd_lookup(upd_lookup),
  .touch_en(touch_en), .touch_idx(touch_idx), .hit_idx(hit_idx),
  .hit_vec(hit_vec), .valid_q(valid_q), .dirty_q(dirty_q), .ranks(ranks)
);

// File: tb/vpage_tlb_tb.sv
module vpage_tlb_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        lk_valid, lk_write;
  logic [15:0] lk_vaddr;
  logic        lk_hit, lk_page_fault, lk_prot_fault, lk_dirty;
  logic [15:0] lk_paddr;
  logic        fill_valid, fill_dirty, base_wr;
  logic [7:0]  fill_vpn, fill_ppn;
  logic [1:0]  fill_perm;
  logic [2:0]  victim_slot;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  vpage_tlb u_dut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_write(lk_write),
    .lk_hit(lk_hit), .lk_paddr(lk_paddr), .lk_page_fault(lk_page_fault),
    .lk_prot_fault(lk_prot_fault), .lk_dirty(lk_dirty), .fill_valid(fill_valid),
    .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_perm(fill_perm),
    .fill_dirty(fill_dirty), .base_wr(base_wr), .victim_slot(victim_slot)
  );

  // Reference model
  logic [7:0] m_vpn  [8];
  logic [7:0] m_ppn  [8];
  logic [1:0] m_perm [8];
  bit         m_val  [8];
  bit         m_dirty[8];
  int         m_rank [8];

  function automatic void m_clear();
    for (int i = 0; i < 8; i++) begin
      m_val[i] = 0; m_dirty[i] = 0; m_rank[i] = i;
    end
  endfunction

  function automatic int m_find(input logic [7:0] vpn);
    for (int i = 0; i < 8; i++) if (m_val[i] && m_vpn[i] == vpn) return i;
    return -1;
  endfunction

  function automatic int m_victim();
    for (int i = 0; i < 8; i++) if (!m_val[i]) return i;
    for (int i = 0; i < 8; i++) if (m_rank[i] == 7) return i;
    return 0;
  endfunction

  function automatic void m_touch(input int t);
    int old = m_rank[t];
    for (int i = 0; i < 8; i++) begin
      if (i == t) m_rank[i] = 0;
      else if (m_rank[i] < old) m_rank[i] = m_rank[i] + 1;
    end
  endfunction

  task automatic chk(input string req, input string ctx, input logic [15:0] act, input logic [15:0] exp);
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s (%s): actual=%h expected=%h", req, ctx, act, exp);
    end
  endtask

  // One cycle: drive at negedge, compare outputs, then advance model at posedge.
  task automatic cyc(input string ctx, input bit lv, input logic [15:0] va, input bit wr,
                     input bit fv, input logic [7:0] fvpn, input logic [7:0] fppn,
                     input logic [1:0] fperm, input bit fd, input bit bw);
    int idx, slot;
    bit e_hit, e_prot, e_dirty;
    logic [15:0] e_pa;
    @(negedge clk);
    lk_valid = lv; lk_vaddr = va; lk_write = wr;
    fill_valid = fv; fill_vpn = fvpn; fill_ppn = fppn; fill_perm = fperm;
    fill_dirty = fd; base_wr = bw;
    #1;
    idx     = lv ? m_find(va[15:8]) : -1;
    e_hit   = (idx >= 0);
    e_pa    = e_hit ? {m_ppn[idx], va[7:0]} : 16'h0;
    e_prot  = e_hit && (wr ? !m_perm[idx][1] : !m_perm[idx][0]);
    e_dirty = e_hit && m_dirty[idx];
    n_tests++;
    chk("R2", ctx, {15'd0, lk_hit}, {15'd0, e_hit});
    chk("R1", ctx, lk_paddr, e_pa);
    chk("R6", ctx, {15'd0, lk_page_fault}, {15'd0, lv && !e_hit});
    chk("R3", ctx, {15'd0, lk_prot_fault}, {15'd0, e_prot});
    chk("R4", ctx, {15'd0, lk_dirty}, {15'd0, e_dirty});
    chk("R7", ctx, {13'd0, victim_slot}, 16'(m_victim()));
    @(posedge clk);
    if (bw) m_clear();
    else if (fv) begin
      slot = m_find(fvpn);
      if (slot < 0) slot = m_victim();
      m_vpn[slot] = fvpn; m_ppn[slot] = fppn; m_perm[slot] = fperm;
      m_val[slot] = 1; m_dirty[slot] = fd;
      m_touch(slot);
    end else if (e_hit && !e_prot) begin
      if (wr) m_dirty[idx] = 1;
      m_touch(idx);
    end
  endtask

  task automatic look(input string ctx, input logic [15:0] va, input bit wr);
    cyc(ctx, 1, va, wr, 0, 8'h0, 8'h0, 2'b0, 0, 0);
  endtask

  task automatic fill(input string ctx, input logic [7:0] vpn, input logic [7:0] ppn,
                      input logic [1:0] perm);
    cyc(ctx, 0, 16'h0, 0, 1, vpn, ppn, perm, 0, 0);
  endtask

  task automatic expect_victim(input string req, input int v);
    @(negedge clk);
    lk_valid = 0; fill_valid = 0; base_wr = 0;
    #1;
    n_tests++;
    chk(req, "victim", {13'd0, victim_slot}, 16'(v));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    rst = 1; lk_valid = 0; lk_vaddr = 0; lk_write = 0; fill_valid = 0;
    fill_vpn = 0; fill_ppn = 0; fill_perm = 0; fill_dirty = 0; base_wr = 0;
    m_clear();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R8: reset state: everything misses, first free slot is 0
    look("R8 reset lookup", 16'h1234, 0);
    expect_victim("R8", 0);

    // R7: fills go to free slots in index order
    for (int i = 0; i < 8; i++) fill("R7 fill free", 8'h10 + 8'(i), 8'h40 + 8'(i), 2'b11);
    // R5: all full, oldest is the first filled (slot 0)
    expect_victim("R5", 0);
    look("R1 read hit", 16'h10ab, 0);
    expect_victim("R5", 1);
    look("R4 write hit", 16'h1122, 1);
    look("R4 dirty visible", 16'h1100, 0);
    // R3: read-only page refuses write, no rank change
    fill("R3 ro page", 8'h15, 8'h77, 2'b01);
    look("R3 write to ro", 16'h1501, 1);
    look("R3 ro read ok", 16'h1502, 0);
    // R7: refill of present vpn reuses its slot
    fill("R7 dup refill", 8'h12, 8'h99, 2'b11);
    look("R7 dup lookup", 16'h12ff, 0);
    // R9: fill and lookup together, lookup does not touch
    cyc("R9 fill+look", 1, 16'h1333, 1, 1, 8'hA0, 8'h01, 2'b11, 1, 0);
    look("R9 after", 16'h13f0, 0);
    // R8: flush wins over fill
    cyc("R8 flush+fill", 0, 16'h0, 0, 1, 8'hB0, 8'h02, 2'b11, 0, 1);
    look("R8 flushed", 16'hB000, 0);
    expect_victim("R8", 0);

    // Constrained random mix
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 999);
      logic [7:0] vpn = 8'h20 + 8'($urandom_range(0, 11));
      if (r < 4)
        cyc("R8 rnd flush", 0, 16'h0, 0, 0, 8'h0, 8'h0, 2'b0, 0, 1);
      else if (r < 250)
        cyc("R7 rnd fill", $urandom_range(0, 1), {8'h20 + 8'($urandom_range(0, 11)), 8'($urandom)},
            $urandom_range(0, 1), 1, vpn, 8'($urandom), 2'($urandom), $urandom_range(0, 1), 0);
      else
        look("R5 rnd look", {vpn, 8'($urandom)}, $urandom_range(0, 1));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule